// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator

This block produces one pulse-width-modulated output whose frequency is set by a fractional step rather than a period count. A 16-bit accumulator adds a programmable step on every clock and wraps modulo 65536. Each wrap marks the end of one output cycle, so the output frequency is the clock frequency times step / 65536. The duty cycle comes from comparing the top byte of the accumulator with an 8-bit threshold. The threshold is inverted: a larger value gives a shorter high time, and it is roughly 255 × (1 − duty).

Software drives the block through one 32-bit word. A write changes only a set of staged fields. The running waveform uses a separate active copy of the step and the threshold. That copy is refreshed only when software sets the update-request bit, and only at the next wrap. The request bit clears itself once the copy is taken, so polling that bit tells software when the new setting is live. Clearing the enable bit parks the accumulator at zero and drives the output low. The staged fields keep their values while the block is disabled.

Top module: `pwm_accum_gen`

## Requirements
- R1: After reset, the readback word is 0x00000000 and the output is low.
- R2: Word layout: bit 31 is enable and bit 30 is the update request. Bits 23:8 hold the step and bits 7:0 hold the threshold. Bits 29:24 read as 0. The step and threshold read back as last written. Bit 30 reads 1 exactly while a request is pending.
- R3: With a running step S that divides 65536, the output period is 65536/S clocks.
- R4: While enabled, the output is high in those clocks where the accumulator's top byte is greater than or equal to the active threshold D. For a step S = 2^k, the high time per period is the number of n in [0, 65536/S) with (n·S)>>8 ≥ D.
- R5: A step of 0x8000 is supported and gives a period of 2 clocks.
- R6: A write with bit 30 clear does not change the running waveform.
- R7: A requested update that arrives mid-cycle leaves the waveform unchanged until the next wrap. The new step and threshold apply from the wrap on.
- R8: The request bit stays set until the active copy is loaded, then clears itself with no further write.
- R9: With enable clear, the output is low and the accumulator is held at 0, while the staged fields keep their values. Setting enable again resumes the output with the held settings.
- R10: A pending request is loaded on the next clock when the block is disabled or the active step is 0, because no cycle is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the accumulator steps on each rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Write strobe for the control word |
| regWdata | input | 32 | Control word to write |
| regRdata | output | 32 | Readback of enable, pending request and staged fields |
| pwmOut | output | 1 | PWM output |

## Verification
The assertions assume that the step is no larger than 0x8000. They also assume that software changes the enable bit only by a full-word write. Nothing else in the block can set the request bit. The stimulus uses power-of-two steps between 0x0100 and 0x8000, so every wrap lands the accumulator exactly on zero. This lets the expected period and high time be stated in whole clocks. Thresholds are kept above 0, so each period has a rising edge to measure from, and the mid-cycle write is timed from an observed rising edge.

// File: rtl/pwm_accum_pkg.sv
package pwm_accum_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic accRun;      // accumulator steps this clock
    logic loadActive;  // copy staged step/threshold into the active copy
  } dpCtrl_t;
endpackage

// File: rtl/pwm_accum_ctrl.sv
module pwm_accum_ctrl
  import pwm_accum_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int BASE_W   = 16,
  parameter int DIV_W    = 8,
  parameter int EN_BIT   = 31,
  parameter int UPD_BIT  = 30,
  parameter int BASE_LSB = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_W-1:0]  regWdata,
  input  logic              wrap,
  input  logic              baseIsZero,
  output logic [REG_W-1:0]  regRdata,
  output logic [BASE_W-1:0] shadowBase,
  output logic [DIV_W-1:0]  shadowDiv,
  output dpCtrl_t           strobes
);
  localparam int BASE_MSB = BASE_LSB + BASE_W - 1;

  logic enable;
  logic pend;
  logic reqSet;
  logic boundary;

  assign reqSet   = regWe && regWdata[UPD_BIT];
  assign boundary = !enable || wrap || baseIsZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable     <= 1'b0;
      shadowBase <= '0;
      shadowDiv  <= '0;
    end else if (regWe) begin
      enable     <= regWdata[EN_BIT];
      shadowBase <= regWdata[BASE_MSB:BASE_LSB];
      shadowDiv  <= regWdata[DIV_W-1:0];
    end
  end

  // Request flag: a new request wins over the self-clear
  always_ff @(posedge clk) begin
    if (!rstN)                            pend <= 1'b0;
    else if (reqSet)                      pend <= 1'b1;
    else if (pend && boundary)            pend <= 1'b0;
  end

  always_comb begin
    strobes.accRun     = enable;
    strobes.loadActive = pend && boundary;
  end

  always_comb begin
    regRdata                    = '0;
    regRdata[EN_BIT]            = enable;
    regRdata[UPD_BIT]           = pend;
    regRdata[BASE_MSB:BASE_LSB] = shadowBase;
    regRdata[DIV_W-1:0]         = shadowDiv;
  end

  // R8: once loaded without a fresh request, the flag reads clear
  p_pend_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadActive && !reqSet) |=> !regRdata[UPD_BIT]);

  // R8: a request stays visible until it is taken
  p_pend_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata[UPD_BIT] && !strobes.loadActive) |=> regRdata[UPD_BIT]);

  // R7: a running cycle is never cut short by a load
  p_no_midcycle_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.accRun && !wrap && !baseIsZero) |-> !strobes.loadActive);
endmodule

// File: rtl/pwm_accum_dp.sv
module pwm_accum_dp
  import pwm_accum_pkg::*;
#(
  parameter int ACC_W  = 16,
  parameter int BASE_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           strobes,
  input  logic [BASE_W-1:0] shadowBase,
  input  logic [DIV_W-1:0]  shadowDiv,
  output logic              wrap,
  output logic              baseIsZero,
  output logic              pwmOut
);
  localparam int TOP_LSB = ACC_W - DIV_W;
  localparam int PAD_W   = ACC_W + 1 - BASE_W;

  logic [ACC_W-1:0]  acc;
  logic [BASE_W-1:0] activeBase;
  logic [DIV_W-1:0]  activeDiv;
  logic [ACC_W:0]    sum;

  assign sum        = {1'b0, acc} + {{PAD_W{1'b0}}, activeBase};
  assign wrap       = strobes.accRun && sum[ACC_W];
  assign baseIsZero = (activeBase == '0);

  always_ff @(posedge clk) begin
    if (!rstN)                acc <= '0;
    else if (!strobes.accRun) acc <= '0;
    else                      acc <= sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeBase <= '0;
      activeDiv  <= '0;
    end else if (strobes.loadActive) begin
      activeBase <= shadowBase;
      activeDiv  <= shadowDiv;
    end
  end

  assign pwmOut = strobes.accRun && (acc[ACC_W-1:TOP_LSB] >= activeDiv);

  // R9: a stopped accumulator sits at zero
  p_acc_parked_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.accRun |=> (acc == '0));

  // R6: the active copy only moves on a load strobe
  p_active_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadActive |=> ($stable(activeBase) && $stable(activeDiv)));

  // R3: after a wrap the remainder is below the step that caused it
  p_wrap_remainder_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> ({1'b0, acc} < {{PAD_W{1'b0}}, $past(activeBase)}));
endmodule

// File: rtl/pwm_accum_gen.sv
module pwm_accum_gen
  import pwm_accum_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ACC_W  = 16,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  output logic             pwmOut
);
  localparam int BASE_W = ACC_W;
  localparam int EN_BIT = REG_W - 1;

  dpCtrl_t           strobes;
  logic [BASE_W-1:0] shadowBase;
  logic [DIV_W-1:0]  shadowDiv;
  logic              wrap;
  logic              baseIsZero;

  pwm_accum_ctrl #(
    .REG_W(REG_W), .BASE_W(BASE_W), .DIV_W(DIV_W),
    .EN_BIT(EN_BIT), .UPD_BIT(EN_BIT - 1), .BASE_LSB(DIV_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .wrap(wrap), .baseIsZero(baseIsZero), .regRdata(regRdata),
    .shadowBase(shadowBase), .shadowDiv(shadowDiv), .strobes(strobes)
  );

  pwm_accum_dp #(
    .ACC_W(ACC_W), .BASE_W(BASE_W), .DIV_W(DIV_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .shadowBase(shadowBase), .shadowDiv(shadowDiv),
    .wrap(wrap), .baseIsZero(baseIsZero), .pwmOut(pwmOut)
  );

  // R9: output is quiet whenever the readback shows enable clear
  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !regRdata[EN_BIT] |-> !pwmOut);
endmodule

// File: tb/pwm_accum_gen_test.sv
module pwm_accum_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {step[15:0], threshold[7:0], period[15:0], high[15:0]}
  localparam logic [55:0] VEC [0:NVEC-1] = '{
    {16'h0100, 8'h80, 16'd256, 16'd128},
    {16'h0400, 8'h40, 16'd64,  16'd48},
    {16'h1000, 8'hF0, 16'd16,  16'd1},
    {16'h8000, 8'h80, 16'd2,   16'd1},
    {16'h0800, 8'h01, 16'd32,  16'd31},
    {16'h2000, 8'h30, 16'd8,   16'd6}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        pwmOut;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_accum_gen uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .pwmOut(pwmOut)
  );

  function automatic logic [31:0] word(input logic en, input logic upd,
                                       input logic [15:0] step, input logic [7:0] thr);
    return {en, upd, 6'b0, step, thr};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic waitLoaded(input string req);
    int n = 0;
    while (regRdata[30] && n < 70000) begin
      @(negedge clk);
      n++;
    end
    chk(req, {31'b0, regRdata[30]}, 32'd0);
  endtask

  // Measure four whole periods from a rising edge
  task automatic measure(output int per4, output int high4);
    logic prev, cur;
    int guard = 0;
    int rises = 0;
    per4 = 0; high4 = 0;
    @(negedge clk); cur = pwmOut;
    do begin
      prev = cur; @(negedge clk); cur = pwmOut; guard++;
    end while (!(prev == 1'b0 && cur == 1'b1) && guard < 70000);
    per4 = 1; high4 = 1;
    while (guard < 70000) begin
      prev = cur; @(negedge clk); cur = pwmOut; guard++;
      if (prev == 1'b0 && cur == 1'b1) begin
        rises++;
        if (rises == 4) break;
      end
      per4++;
      if (cur) high4++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int p4, h4;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 readback", regRdata, 32'h0);
    chk("R1 output", {31'b0, pwmOut}, 32'd0);

    // R10: request while disabled loads on the next clock
    wr(word(1'b0, 1'b1, 16'h0100, 8'h80));
    @(negedge clk);
    chk("R10 disabled load", regRdata, 32'h0001_0080);
    chk("R9 idle low", {31'b0, pwmOut}, 32'd0);

    wr(word(1'b1, 1'b0, 16'h0100, 8'h80));
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] st; logic [7:0] th; int per, hi;
      st = VEC[i][55:40]; th = VEC[i][39:32];
      per = int'(VEC[i][31:16]); hi = int'(VEC[i][15:0]);
      wr(word(1'b1, 1'b1, st, th));
      waitLoaded("R8 self-clear");
      chk("R2 readback", regRdata, word(1'b1, 1'b0, st, th));
      measure(p4, h4);
      chk((st == 16'h8000) ? "R5 period" : "R3 period", p4, 4 * per);
      chk("R4 high time", h4, 4 * hi);
    end

    // R6: staged write without request leaves waveform alone
    wr(word(1'b1, 1'b0, 16'h0100, 8'h80));
    chk("R6 staged readback", regRdata, 32'h8001_0080);
    measure(p4, h4);
    chk("R6 period unchanged", p4, 32);
    chk("R6 high unchanged", h4, 24);

    // Now request the staged values
    wr(word(1'b1, 1'b1, 16'h0100, 8'h80));
    waitLoaded("R8 self-clear");
    measure(p4, h4);
    chk("R3 period 256", p4, 1024);
    chk("R4 high 128", h4, 512);

    // R7: mid-cycle request right after a rising edge
    begin
      logic prev, cur; int g = 0; int bad = 0; int pendLost = 0;
      @(negedge clk); cur = pwmOut;
      do begin prev = cur; @(negedge clk); cur = pwmOut; g++; end
      while (!(prev == 1'b0 && cur == 1'b1) && g < 1000);
      wr(word(1'b1, 1'b1, 16'h0100, 8'hC0));
      for (int k = 0; k < 100; k++) begin
        @(negedge clk);
        if (!pwmOut) bad++;
        if (!regRdata[30]) pendLost++;
      end
      chk("R7 held until wrap", bad, 0);
      chk("R8 pending visible", pendLost, 0);
    end
    waitLoaded("R8 self-clear");
    measure(p4, h4);
    chk("R7 new period", p4, 1024);
    chk("R7 new high", h4, 256);

    // R9: disable keeps fields, output low
    wr(word(1'b0, 1'b0, 16'h0100, 8'hC0));
    begin
      int hiSeen = 0;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (pwmOut) hiSeen++;
      end
      chk("R9 low while off", hiSeen, 0);
    end
    chk("R9 fields kept", regRdata, 32'h0001_00C0);
    wr(word(1'b1, 1'b0, 16'h0100, 8'hC0));
    measure(p4, h4);
    chk("R9 resume period", p4, 1024);
    chk("R9 resume high", h4, 256);

    // R10: disabled request then enable
    wr(word(1'b0, 1'b1, 16'h1000, 8'h80));
    @(negedge clk);
    chk("R10 loads when off", {31'b0, regRdata[30]}, 32'd0);
    wr(word(1'b1, 1'b0, 16'h1000, 8'h80));
    measure(p4, h4);
    chk("R10 period", p4, 64);
    chk("R10 high", h4, 32);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule